// File: doc/BRIEF.md
# Line-Transition Bit Decoder with Zero-Run Unstuffing

This block sits behind a clock-recovery stage and turns recovered line levels into logical data bits. Each recovered bit period arrives as one sample of the line level, marked by a single-cycle sample strobe. A level change relative to the previous sample means a logical one, and an unchanged level means a logical zero. The transmitter forces a transition after every run of six zeros, so the receiver has edges to track on. This block removes those forced ones, so that only payload bits reach the output.

If the forced transition is missing, the block raises a one-cycle error pulse. It drops that bit and starts counting the zero run again from nothing. The first strobe after reset only records the line level, so the line may rest at either level before traffic starts. Everything runs in one clock domain with clock enables only. Decoded bits leave through registered outputs, one clock after their strobe.

Top module: `nrzi_unstuff`

## Requirements
- R1: A strobed sample whose level differs from the previous strobed sample produces out_vld=1 with out_bit=1 one clock later, unless it is the forced bit of R3.
- R2: A strobed sample whose level equals the previous strobed sample produces out_vld=1 with out_bit=0 one clock later, unless it falls in the forced position of R6.
- R3: After RUN_LEN (default 6) consecutive decoded zeros, a transition on the next strobed sample is a forced one. It produces neither out_vld nor stuff_err.
- R4: A line carrying only zeros toggles once every seven strobes. It is decoded without limit, giving zeros only and never out_bit=1 or stuff_err.
- R5: The decoded stream is the same whether the line starts low or high.
- R6: After RUN_LEN consecutive decoded zeros, an unchanged level on the next strobed sample makes stuff_err high for exactly one clock, one clock after that strobe. That bit gives out_vld=0.
- R7: After a stuffing error the zero-run count restarts at zero. The next RUN_LEN zeros decode as data, and only the sample after them is treated as forced.
- R8: Every decoded one, payload or forced, clears the zero-run count.
- R9: The first strobed sample after reset only records the line level. It produces neither out_vld nor stuff_err.
- R10: Without a strobe, out_vld and stuff_err stay 0 one clock later. Level changes on smp_lvl while smp_vld=0 have no effect on later decoding.
- R11: Synchronous active-high reset clears the zero-run count, the recorded level and all outputs, including in the middle of a zero run.
- R12: out_vld and stuff_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Strobe: smp_lvl holds one recovered bit-period sample |
| smp_lvl | input | 1 | Recovered line level |
| out_vld | output | 1 | Registered strobe for a decoded payload bit |
| out_bit | output | 1 | Decoded payload bit, meaningful when out_vld=1 |
| stuff_err | output | 1 | One-cycle pulse when a forced transition is missing |

## Verification
At the forced position after six zeros, the stuffing check and the ordinary transition decode act on the same sample in the same cycle. That is the point where a wrong ordering between the two would show. The sweep reaches this point with every 8-bit payload pattern, encoded by a transmitter model in the bench, once from each starting level. Idle strobe gaps are placed so that they sometimes fall right before a forced sample. Directed cases remove the forced transition, or reset in the middle of a run. Each sample is then judged on the three outputs in the cycle after its strobe.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;
  // classification of one strobed line sample after decode
  typedef enum logic [1:0] {
    SYM_NONE  = 2'd0,  // no strobe, or priming sample
    SYM_DATA  = 2'd1,  // payload bit, forwarded
    SYM_STUFF = 2'd2,  // forced one, dropped
    SYM_ERR   = 2'd3   // forced one missing
  } sym_kind_e;
endpackage

// File: rtl/nrzi_level_track.sv
module nrzi_level_track (
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  input  logic smp_lvl,
  output logic edge_vld,
  output logic edge_bit
);
  logic prev_lvl;
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= 1'b0;
      primed   <= 1'b0;
    end else if (smp_vld) begin
      prev_lvl <= smp_lvl;
      primed   <= 1'b1;
    end
  end

  // transition between strobed samples decodes as one
  always_comb begin
    edge_vld = smp_vld & primed;
    edge_bit = smp_lvl ^ prev_lvl;
  end
endmodule

// File: rtl/nrzi_run_track.sv
module nrzi_run_track
  import nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      edge_vld,
  input  logic      edge_bit,
  output sym_kind_e kind
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [RUN_W-1:0] run_cnt;
  logic             at_limit;

  assign at_limit = (run_cnt == RUN_W'(RUN_LEN));

  always_comb begin
    if (!edge_vld)     kind = SYM_NONE;
    else if (at_limit) kind = edge_bit ? SYM_STUFF : SYM_ERR;
    else               kind = SYM_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (edge_vld) begin
      if (at_limit || edge_bit) run_cnt <= '0;
      else                      run_cnt <= run_cnt + RUN_W'(1);
    end
  end
endmodule

// File: rtl/nrzi_out_stage.sv
module nrzi_out_stage
  import nrzi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  sym_kind_e kind,
  input  logic      edge_bit,
  output logic      out_vld,
  output logic      out_bit,
  output logic      stuff_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_bit   <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      out_vld   <= (kind == SYM_DATA);
      stuff_err <= (kind == SYM_ERR);
      if (kind == SYM_DATA) out_bit <= edge_bit;
    end
  end
endmodule

// File: rtl/nrzi_unstuff.sv
module nrzi_unstuff
  import nrzi_pkg::*;
#(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  input  logic smp_lvl,
  output logic out_vld,
  output logic out_bit,
  output logic stuff_err
);
  logic      edge_vld;
  logic      edge_bit;
  sym_kind_e kind;

  nrzi_level_track u_level (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .smp_lvl  (smp_lvl),
    .edge_vld (edge_vld),
    .edge_bit (edge_bit)
  );

  nrzi_run_track #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst      (rst),
    .edge_vld (edge_vld),
    .edge_bit (edge_bit),
    .kind     (kind)
  );

  nrzi_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .edge_bit  (edge_bit),
    .out_vld   (out_vld),
    .out_bit   (out_bit),
    .stuff_err (stuff_err)
  );
endmodule

// File: rtl/nrzi_unstuff_chk.sv
module nrzi_unstuff_chk (
  input logic clk,
  input logic rst,
  input logic smp_vld,
  input logic smp_lvl,
  input logic out_vld,
  input logic out_bit,
  input logic stuff_err
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst)          seen <= 1'b0;
    else if (smp_vld) seen <= 1'b1;
  end

  // R12: payload strobe and error pulse are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_vld && stuff_err));

  // R10: an output strobe needs a sample strobe one clock earlier
  a_r10_vld_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($past(smp_vld) && !$past(rst)));

  // R6: an error pulse needs a sample strobe one clock earlier
  a_r6_err_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    stuff_err |-> ($past(smp_vld) && !$past(rst)));

  // R6 and R7: the error lasts one clock, since the run restarts
  a_r6_err_single: assert property (@(posedge clk) disable iff (rst)
    stuff_err |=> !stuff_err);

  // R9: the priming sample yields nothing
  a_r9_prime_silent: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !seen) |=> (!out_vld && !stuff_err));

  logic unused_ok;
  assign unused_ok = smp_lvl ^ out_bit;
endmodule

bind nrzi_unstuff nrzi_unstuff_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_vld   (smp_vld),
  .smp_lvl   (smp_lvl),
  .out_vld   (out_vld),
  .out_bit   (out_bit),
  .stuff_err (stuff_err)
);

// File: tb/test_nrzi_unstuff.sv
module test_nrzi_unstuff;
  localparam int RUN = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic smp_lvl = 1'b0;
  logic out_vld, out_bit, stuff_err;

  int n_vec  = 0;
  int n_fail = 0;

  // transmitter model state
  logic tx_lvl = 1'b0;
  int   tx_zc  = 0;

  always #2 clk = ~clk;  // 250 MHz

  nrzi_unstuff #(.RUN_LEN(RUN)) i_nrzi_unstuff (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .smp_lvl   (smp_lvl),
    .out_vld   (out_vld),
    .out_bit   (out_bit),
    .stuff_err (stuff_err)
  );

  // drive one cycle at a falling edge, judge the outputs at the next falling edge
  task automatic push(input logic v, input logic l, input logic ev,
                      input logic eb, input logic ee, input string tag);
    smp_vld = v;
    smp_lvl = l;
    @(negedge clk);
    n_vec++;
    if (out_vld !== ev || stuff_err !== ee || (ev && out_bit !== eb) ||
        (out_vld === 1'b1 && stuff_err === 1'b1)) begin
      n_fail++;
      $display("FAIL %s: vld/bit/err actual %b/%b/%b expected %b/%b/%b",
               tag, out_vld, out_bit, stuff_err, ev, eb, ee);
    end
  endtask

  // transmitter: forced one goes out before the bit that follows six zeros
  task automatic tx_bit(input logic b, input string tag);
    if (tx_zc == RUN) begin
      tx_lvl = ~tx_lvl;
      push(1'b1, tx_lvl, 1'b0, 1'b0, 1'b0, {tag, "/R3"});
      tx_zc = 0;
    end
    if (b) tx_lvl = ~tx_lvl;
    push(1'b1, tx_lvl, 1'b1, b, 1'b0, {tag, b ? "/R1" : "/R2"});
    tx_zc = b ? 0 : tx_zc + 1;
  endtask

  task automatic gap(input string tag);
    push(1'b0, ~tx_lvl, 1'b0, 1'b0, 1'b0, {tag, "/R10"});
  endtask

  task automatic do_reset(input logic start);
    rst = 1'b1;
    push(1'b1, ~start, 1'b0, 1'b0, 1'b0, "R11 in reset");
    push(1'b0, start, 1'b0, 1'b0, 1'b0, "R11 in reset");
    rst = 1'b0;
    push(1'b1, start, 1'b0, 1'b0, 1'b0, "R9 prime");
    tx_lvl = start;
    tx_zc  = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // sweep all byte patterns from both resting levels
    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      for (int v = 0; v < 256; v++) begin
        for (int i = 0; i < 8; i++) begin
          tx_bit(v[i], s ? "R5 sweep" : "sweep");
          if (((v + i) % 13) == 0) gap("sweep");
        end
      end
    end

    // R4: long idle stretch of zeros
    do_reset(1'b0);
    for (int i = 0; i < 140; i++) tx_bit(1'b0, "R4 idle");

    // R8: a one clears the run, no forced bit after 5+1+5
    do_reset(1'b1);
    for (int i = 0; i < 5; i++) tx_bit(1'b0, "R8");
    tx_bit(1'b1, "R8");
    for (int i = 0; i < 5; i++) tx_bit(1'b0, "R8");
    tx_bit(1'b1, "R8");

    // R6 then R7: missing forced transition, run restarts afterwards
    for (int i = 0; i < RUN; i++) tx_bit(1'b0, "R6 lead");
    push(1'b1, tx_lvl, 1'b0, 1'b0, 1'b1, "R6 error");
    tx_zc = 0;
    push(1'b0, tx_lvl, 1'b0, 1'b0, 1'b0, "R6 one-cycle pulse");
    for (int i = 0; i < RUN; i++) tx_bit(1'b0, "R7");
    tx_bit(1'b0, "R7");
    tx_bit(1'b1, "R7");

    // R11: reset in the middle of a zero run
    for (int i = 0; i < 4; i++) tx_bit(1'b0, "R11 pre");
    do_reset(1'b1);
    for (int i = 0; i < RUN + 1; i++) tx_bit(1'b0, "R11 post");
    tx_bit(1'b1, "R11 post");

    // R12 exclusivity is judged inside every push
    smp_vld = 1'b0;
    push(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12 tail");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule